// File: doc/BRIEF.md
# Keyed Configuration Item Reader

This block gives a host read access to a set of numbered configuration items held in an on-chip table. Each item is identified by a 16-bit key and has a byte length and byte contents. The host first writes a key to a control window. It then pulls the item out as a byte stream through a data window. A running byte offset moves forward by the number of bytes each read returns.

There are two item tables, a generic one and an architecture-local one. One key bit chooses the table and the lower key bits index into it. A data read can be 1, 2, 4 or 8 bytes wide. Bytes are packed so that the earliest item byte is the most significant byte of the result. When the item runs out, the remaining low bytes are padded with zero.

A third, combined window serves port-style hosts. In it, a byte access goes to the data path and a 16-bit write loads the key. Every read request gets a registered response one cycle later. Writes never produce a response.

Top module: `cfg_item_reader`

## Requirements
- R1: After reset, the selected item is generic key 0 at offset 0, so a 4-byte data read returns 0x3C3D3E3F.
- R2: A write with size code 1 to the control window (bus_win 0) selects key bus_wdata[15:0] and sets the offset to 0.
- R3: Key bit 14 selects the architecture-local table (1) or the generic table (0), and bits 13:0 give the index. Key bit 15 is ignored.
- R4: A key whose index is at or above MAX_ENTRIES (24) selects an invalid entry, and every data read then returns zero.
- R5: A data read of N = 2^bus_size bytes places item byte offset+j at result byte N-1-j, with bits above 8N zero. The offset then advances by N.
- R6: If fewer than N bytes remain, the lower result bytes are zero and the offset stops at the item length.
- R7: An item of length zero, or one whose offset has reached its length, reads as zero.
- R8: Reads of the control window return zero. Control writes with a size code other than 1 change nothing, and reads of window 3 return zero.
- R9: In the combined window (bus_win 2), a size-0 read is a data read and a size-1 write selects a key. Reads with a size code other than 0 return zero and leave the offset unchanged.
- R10: Writes to the data window (bus_win 1), and size-0 writes to the combined window, are discarded and leave the offset unchanged.
- R11: Every read request gets bus_rvalid exactly one cycle later and writes get none. bus_rdata is zero in any cycle without bus_rvalid.
- R12: Item (t,i) has length (3i + 5t + 4) mod 9. Its byte at offset o is ((16i + o) mod 256) XOR 0x3C for t=0, or XOR 0xA5 for t=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_win | input | 2 | Window: 0 control, 1 data, 2 combined, 3 unused |
| bus_size | input | 2 | Access size code, bytes = 2^code |
| bus_wdata | input | 64 | Write data; the key sits in the low 16 bits |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 64 | Read response data |

## Verification
The assertions assume that a request is single-cycle: bus_req is sampled once per access, with no flow control. They also assume that the invalid-key property sees a data read issued directly after its select write. The bench drives each access for exactly one clock and deasserts bus_req between tasks. Back-to-back select-then-read pairs are used so that the invalid-key assertion is exercised. All keys, sizes and windows come from a fixed list that covers both tables, out-of-range indices, every size code and every window.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;
   typedef enum logic [1:0] {
      WIN_CTL  = 2'd0,
      WIN_DATA = 2'd1,
      WIN_COMB = 2'd2,
      WIN_NONE = 2'd3
   } win_e;

   localparam logic [1:0] SZ_SELECT = 2'd1;
   localparam logic [1:0] SZ_BYTE   = 2'd0;
endpackage

// File: rtl/cfg_item_rom.sv
module cfg_item_rom #(
   parameter int IDX_W   = 14,
   parameter int OFF_W   = 32,
   parameter int LANES   = 8,
   parameter int LEN_MOD = 9,
   parameter logic [7:0] XOR_GEN  = 8'h3C,
   parameter logic [7:0] XOR_ARCH = 8'hA5
) (
   input  logic             tbl,
   input  logic [IDX_W-1:0] idx,
   input  logic [OFF_W-1:0] off,
   output logic [OFF_W-1:0] len,
   output logic [7:0]       lane_byte [LANES]
);
   logic [7:0] salt;

   always_comb begin
      len  = OFF_W'((3 * int'(idx) + 5 * int'(tbl) + 4) % LEN_MOD);
      salt = tbl ? XOR_ARCH : XOR_GEN;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [OFF_W-1:0] lane_off;
      always_comb begin
         lane_off     = off + OFF_W'(g);
         lane_byte[g] = 8'(int'(idx) * 16 + int'(lane_off[7:0])) ^ salt;
      end
   end
endmodule

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
   import cfg_item_pkg::*;
#(
   parameter int LANES    = 8,
   parameter bit HAS_COMB = 1'b1,
   parameter int OFF_W    = 32
) (
   input  logic             req,
   input  logic             wr,
   input  logic [1:0]       win,
   input  logic [1:0]       size,
   output logic             sel_wr,
   output logic             data_rd,
   output logic [OFF_W-1:0] rd_n
);
   localparam int MAX_SZ = $clog2(LANES);

   win_e w;
   logic ctl_sel, dat_rd, comb_sel, comb_rd;

   always_comb begin
      w       = win_e'(win);
      ctl_sel = req && wr && (w == WIN_CTL) && (size == SZ_SELECT);
      dat_rd  = req && !wr && (w == WIN_DATA) && (int'(size) <= MAX_SZ);
   end

   if (HAS_COMB) begin : g_comb
      always_comb begin
         comb_sel = req && wr && (w == WIN_COMB) && (size == SZ_SELECT);
         comb_rd  = req && !wr && (w == WIN_COMB) && (size == SZ_BYTE);
      end
   end else begin : g_no_comb
      always_comb begin
         comb_sel = 1'b0;
         comb_rd  = 1'b0;
      end
   end

   always_comb begin
      sel_wr  = ctl_sel | comb_sel;
      data_rd = dat_rd | comb_rd;
      rd_n    = OFF_W'(1) << size;
   end
endmodule

// File: rtl/cfg_select_state.sv
module cfg_select_state #(
   parameter int ARCH_BIT    = 14,
   parameter int MAX_ENTRIES = 24,
   parameter int OFF_W       = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel_wr,
   input  logic [ARCH_BIT:0]   key,
   input  logic                adv_en,
   input  logic [OFF_W-1:0]    adv,
   output logic                cur_valid,
   output logic                cur_tbl,
   output logic [ARCH_BIT-1:0] cur_idx,
   output logic [OFF_W-1:0]    cur_off
);
   logic key_ok;

   always_comb key_ok = int'(key[ARCH_BIT-1:0]) < MAX_ENTRIES;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_valid <= (MAX_ENTRIES > 0);
         cur_tbl   <= 1'b0;
         cur_idx   <= '0;
         cur_off   <= '0;
      end else if (sel_wr) begin
         cur_valid <= key_ok;
         cur_tbl   <= key[ARCH_BIT];
         cur_idx   <= key[ARCH_BIT-1:0];
         cur_off   <= '0;
      end else if (adv_en) begin
         cur_off   <= cur_off + adv;
      end
   end
endmodule

// File: rtl/cfg_read_pack.sv
module cfg_read_pack #(
   parameter int LANES = 8,
   parameter int OFF_W = 32
) (
   input  logic               valid,
   input  logic [OFF_W-1:0]   len,
   input  logic [OFF_W-1:0]   off,
   input  logic [OFF_W-1:0]   rd_n,
   input  logic [7:0]         lane_byte [LANES],
   output logic [OFF_W-1:0]   take,
   output logic [LANES*8-1:0] packed_data
);
   logic [OFF_W-1:0] avail;

   always_comb begin
      avail = (valid && (off < len)) ? (len - off) : '0;
      take  = (avail < rd_n) ? avail : rd_n;
   end

   for (genvar p = 0; p < LANES; p++) begin : g_pos
      always_comb begin
         packed_data[p*8 +: 8] = 8'h00;
         for (int j = 0; j < LANES; j++) begin
            if ((OFF_W'(j + p + 1) == rd_n) && (OFF_W'(j) < take))
               packed_data[p*8 +: 8] = lane_byte[j];
         end
      end
   end
endmodule

// File: rtl/cfg_item_reader.sv
module cfg_item_reader
   import cfg_item_pkg::*;
#(
   parameter int LANES       = 8,
   parameter int KEY_W       = 16,
   parameter int ARCH_BIT    = 14,
   parameter int MAX_ENTRIES = 24,
   parameter int OFF_W       = 32,
   parameter int LEN_MOD     = 9,
   parameter bit HAS_COMB    = 1'b1,
   localparam int BUS_W      = LANES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_req,
   input  logic             bus_wr,
   input  logic [1:0]       bus_win,
   input  logic [1:0]       bus_size,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic             bus_rvalid,
   output logic [BUS_W-1:0] bus_rdata
);
   if (!(LANES == 1 || LANES == 2 || LANES == 4 || LANES == 8)) begin : g_bad_lanes
      $error("LANES must be 1, 2, 4 or 8");
   end
   if (!(ARCH_BIT < KEY_W && KEY_W <= BUS_W && ARCH_BIT + 1 < BUS_W)) begin : g_bad_key
      $error("key layout does not fit the bus");
   end
   if (MAX_ENTRIES > (1 << ARCH_BIT) || MAX_ENTRIES < 1) begin : g_bad_max
      $error("MAX_ENTRIES out of range");
   end

   logic                sel_wr, data_rd;
   logic [OFF_W-1:0]    rd_n, take, item_len;
   logic                cur_valid, cur_tbl;
   logic [ARCH_BIT-1:0] cur_idx;
   logic [OFF_W-1:0]    cur_off;
   logic [7:0]          lane_byte [LANES];
   logic [BUS_W-1:0]    packed_data;
   logic                unused_wdata;

   always_comb unused_wdata = ^bus_wdata[BUS_W-1:ARCH_BIT+1];

   cfg_access_decode #(.LANES(LANES), .HAS_COMB(HAS_COMB), .OFF_W(OFF_W)) dec_i (
      .req(bus_req), .wr(bus_wr), .win(bus_win), .size(bus_size),
      .sel_wr(sel_wr), .data_rd(data_rd), .rd_n(rd_n)
   );

   cfg_select_state #(.ARCH_BIT(ARCH_BIT), .MAX_ENTRIES(MAX_ENTRIES), .OFF_W(OFF_W)) st_i (
      .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .key(bus_wdata[ARCH_BIT:0]),
      .adv_en(data_rd), .adv(take),
      .cur_valid(cur_valid), .cur_tbl(cur_tbl), .cur_idx(cur_idx), .cur_off(cur_off)
   );

   cfg_item_rom #(.IDX_W(ARCH_BIT), .OFF_W(OFF_W), .LANES(LANES), .LEN_MOD(LEN_MOD)) rom_i (
      .tbl(cur_tbl), .idx(cur_idx), .off(cur_off), .len(item_len), .lane_byte(lane_byte)
   );

   cfg_read_pack #(.LANES(LANES), .OFF_W(OFF_W)) pack_i (
      .valid(cur_valid), .len(item_len), .off(cur_off), .rd_n(rd_n),
      .lane_byte(lane_byte), .take(take), .packed_data(packed_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_req && !bus_wr;
         bus_rdata  <= data_rd ? packed_data : '0;
      end
   end
endmodule

// File: rtl/cfg_item_reader_chk.sv
module cfg_item_reader_chk
   import cfg_item_pkg::*;
#(
   parameter int BUS_W       = 64,
   parameter int ARCH_BIT    = 14,
   parameter int MAX_ENTRIES = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_req,
   input logic             bus_wr,
   input logic [1:0]       bus_win,
   input logic [1:0]       bus_size,
   input logic [BUS_W-1:0] bus_wdata,
   input logic             bus_rvalid,
   input logic [BUS_W-1:0] bus_rdata
);
   assert_read_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_wr) |=> bus_rvalid);

   assert_no_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_wr) |=> !bus_rvalid);

   assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rvalid |-> (bus_rdata == '0));

   assert_ctl_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_wr && bus_win == WIN_CTL) |=> (bus_rdata == '0));

   assert_comb_wide_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_wr && bus_win == WIN_COMB && bus_size != 2'd0) |=> (bus_rdata == '0));

   assert_byte_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_wr && bus_size == 2'd0) |=> (bus_rdata[BUS_W-1:8] == '0));

   assert_invalid_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_wr && bus_win == WIN_CTL && bus_size == 2'd1 &&
       int'(bus_wdata[ARCH_BIT-1:0]) >= MAX_ENTRIES)
      ##1 (bus_req && !bus_wr && bus_win == WIN_DATA) |=> (bus_rdata == '0));
endmodule

bind cfg_item_reader cfg_item_reader_chk #(
   .BUS_W(BUS_W), .ARCH_BIT(ARCH_BIT), .MAX_ENTRIES(MAX_ENTRIES)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
   .bus_win(bus_win), .bus_size(bus_size), .bus_wdata(bus_wdata),
   .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
);

// File: tb/cfg_item_reader_tb_top.sv
`timescale 1ns/1ps
module cfg_item_reader_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_wr = 1'b0;
   logic [1:0]  bus_win = 2'd0, bus_size = 2'd0;
   logic [63:0] bus_wdata = '0;
   logic        bus_rvalid;
   logic [63:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [63:0] exp_q [$];
   string       tag_q [$];

   bit m_valid = 1'b1, m_tbl = 1'b0;
   int m_idx = 0, m_off = 0;

   always #4 clk = ~clk;

   cfg_item_reader dut_i (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_win(bus_win), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
   );

   // R12 content rule
   function automatic int m_len(bit t, int i);
      return (3 * i + 5 * int'(t) + 4) % 9;
   endfunction

   function automatic logic [7:0] m_byte(bit t, int i, int o);
      return 8'((i * 16 + o) & 255) ^ (t ? 8'hA5 : 8'h3C);
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: one access per call, expectation pushed for reads
   task automatic issue(input bit wr, input logic [1:0] win, input logic [1:0] size,
                        input logic [63:0] wd, input string tag);
      logic [63:0] e;
      int n;
      if (!wr) begin
         e = '0;
         if (win == 2'd1 || (win == 2'd2 && size == 2'd0)) begin
            n = 1 << size;
            for (int j = 0; j < n; j++) begin
               if (m_valid && m_off < m_len(m_tbl, m_idx)) begin
                  e = e | (64'(m_byte(m_tbl, m_idx, m_off)) << (8 * (n - 1 - j)));
                  m_off++;
               end
            end
         end
         exp_q.push_back(e);
         tag_q.push_back(tag);
      end else if ((win == 2'd0 || win == 2'd2) && size == 2'd1) begin
         m_idx   = int'(wd[13:0]);
         m_tbl   = wd[14];
         m_valid = m_idx < 24;
         m_off   = 0;
      end
      bus_req = 1'b1; bus_wr = wr; bus_win = win; bus_size = size; bus_wdata = wd;
      @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R11 unexpected response", bus_rdata, '0);
         end else begin
            automatic logic [63:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(bus_rdata === e, t, bus_rdata, e);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(bus_rvalid === 1'b0 && bus_rdata === '0, "R11 reset outputs", bus_rdata, '0);
      rst_n = 1'b1;
      @(negedge clk);
      issue(0, 2'd1, 2'd2, '0, "R1 signature after reset");
      issue(0, 2'd1, 2'd0, '0, "R7 offset at end");
      issue(1, 2'd0, 2'd1, 64'h0002, "R2 select");
      issue(0, 2'd1, 2'd3, '0, "R6 pad past end");
      issue(1, 2'd0, 2'd1, 64'h0001, "R2 select key1");
      issue(0, 2'd1, 2'd1, '0, "R5 two-byte read");
      issue(0, 2'd1, 2'd2, '0, "R5 four-byte read");
      issue(0, 2'd1, 2'd1, '0, "R6 clamp read");
      issue(0, 2'd1, 2'd0, '0, "R6 offset clamped");
      issue(1, 2'd0, 2'd1, 64'h4001, "R3 arch select");
      issue(0, 2'd1, 2'd2, '0, "R3 arch table read");
      issue(1, 2'd0, 2'd1, 64'h4000, "R7 empty item select");
      issue(0, 2'd1, 2'd3, '0, "R7 zero-length item");
      issue(1, 2'd0, 2'd1, 64'h8001, "R3 bit15 select");
      issue(0, 2'd1, 2'd3, '0, "R3 bit15 ignored");
      issue(1, 2'd0, 2'd1, 64'h0018, "R4 invalid select");
      issue(0, 2'd1, 2'd3, '0, "R4 invalid read");
      issue(1, 2'd0, 2'd1, 64'h401E, "R4 invalid arch select");
      issue(0, 2'd1, 2'd0, '0, "R4 invalid arch read");
      issue(1, 2'd0, 2'd1, 64'h0017, "R2 last valid select");
      issue(0, 2'd0, 2'd1, '0, "R8 control read zero");
      issue(1, 2'd0, 2'd2, 64'h0001, "R8 wide control write ignored");
      issue(0, 2'd1, 2'd0, '0, "R8 selection kept");
      issue(0, 2'd3, 2'd0, '0, "R8 window 3 read zero");
      issue(1, 2'd1, 2'd0, 64'hFF, "R10 data write");
      issue(1, 2'd2, 2'd0, 64'hFF, "R10 comb byte write");
      issue(0, 2'd1, 2'd0, '0, "R10 offset unchanged");
      issue(1, 2'd2, 2'd1, 64'h0001, "R9 comb select");
      issue(0, 2'd2, 2'd0, '0, "R9 comb byte read");
      issue(0, 2'd2, 2'd1, '0, "R9 comb wide read zero");
      issue(0, 2'd2, 2'd2, '0, "R9 comb four-byte read zero");
      issue(0, 2'd2, 2'd0, '0, "R9 comb offset unchanged");
      issue(1, 2'd0, 2'd1, 64'h0007, "R12 select key7");
      issue(0, 2'd1, 2'd3, '0, "R12 key7 full read");
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R11 all reads answered", 64'(exp_q.size()), '0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule